// File: doc/BRIEF.md
# Key-Protected Commit Register Guard

This block holds a small per-pin function-select register and guards it in two stages. A lock register sits on a simple register bus. Writing one specific 32-bit key to it opens the lock, and writing any other value closes it again. While the lock is open, software may load an 8-bit commit mask. A write to the function-select register then changes only the bit positions whose commit bits are set. Every other position keeps its old value.

The intended use is to protect pins whose function must not be switched by accident. Software opens the lock, narrows the commit mask to the pins it is allowed to move, and closes the lock again. From then on, writes to the function-select register can reach only those pins. The current function-select value is driven out to the pin-muxing logic.

Top module: `keyed_commit_guard`

## Requirements
- R1: After a synchronous active-low reset, the lock is closed (a lock read returns 1), the commit mask reads 0xFF and the function-select register reads 0x00.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x008) opens the lock, so a later lock read returns 0.
- R3: A write of any other value to the lock register closes the lock, including values that differ from the key in a single bit.
- R4: A write to the commit register (offset 0x00C) while the lock is closed leaves the commit mask unchanged.
- R5: A write to the commit register while the lock is open stores bits 7:0 of the write data. The upper bits are discarded.
- R6: A write to the function-select register (offset 0x000) updates bit i only when commit bit i is 1. Bits whose commit bit is 0 keep their previous value.
- R7: The lock state changes only on writes to the lock register. Commit and function-select writes leave it as it is.
- R8: Reads of the commit and function-select registers return their 8-bit value with zeros in bits 31:8. A read of any unmapped offset returns 0, and a write to an unmapped offset changes no state.
- R9: State changes only at a rising clock edge where the write strobe is high. An address and data presented with the strobe low have no effect.
- R10: Read data is combinational from the address and reflects the state left by the most recent clock edge. The function-select output always equals the stored register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset, shared by reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register at `addr` |
| func_sel | output | 8 | Current function-select register |

## Verification
Each write takes effect at the clock edge where it is presented. Its result appears on `rd_data` and `func_sel` in the very next cycle, with no further latency. Read data depends only on the address and the current state, so a read returns its value in the same cycle it is presented. The bench applies inputs on the falling edge and compares `rd_data` and `func_sel` with a behavioural model one nanosecond later, before the next rising edge. The model is updated right after each rising edge, so every cycle checks the state that the previous write left behind.

// File: rtl/kcg_pkg.sv
// Package: shared constants and the register-select type for the keyed
// commit guard. Assumes the offsets fit within the address width used by
// the top module.
package kcg_pkg;
    parameter int KCG_ADDR_W = 12;
    parameter int KCG_DATA_W = 32;
    parameter int KCG_FS_W   = 8;

    localparam int OFS_FSEL   = 'h000;
    localparam int OFS_LOCK   = 'h008;
    localparam int OFS_COMMIT = 'h00C;

    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_FSEL   = 2'd1,
        SEL_LOCK   = 2'd2,
        SEL_COMMIT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/kcg_addr_decode.sv
// Module: maps a byte offset to one register select.
// Assumes the offsets are distinct. Any other offset decodes to SEL_NONE.
module kcg_addr_decode #(
    parameter int ADDR_W = kcg_pkg::KCG_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output kcg_pkg::reg_sel_e sel
);
    import kcg_pkg::*;

    // Decode the offset to a register select.
    always_comb begin
        if (addr == ADDR_W'(OFS_FSEL))        sel = SEL_FSEL;
        else if (addr == ADDR_W'(OFS_LOCK))   sel = SEL_LOCK;
        else if (addr == ADDR_W'(OFS_COMMIT)) sel = SEL_COMMIT;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/kcg_lock_ctrl.sv
// Module: lock state. A write of the key opens the lock, and any other write
// closes it. Assumes wr_hit is already qualified by the strobe and address.
module kcg_lock_ctrl #(
    parameter int DATA_W = kcg_pkg::KCG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    import kcg_pkg::*;

    logic key_match;

    // Compare the write data with the unlock key.
    always_comb key_match = (wdata == DATA_W'(UNLOCK_KEY));

    // Lock flop: set at reset, updated only on a lock write.
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b1;
        else if (wr_hit) locked <= !key_match;
    end
endmodule

// File: rtl/kcg_commit_reg.sv
// Module: commit mask. It loads only when addressed and the lock is open.
// Assumes wdata is already cut to the mask width.
module kcg_commit_reg #(
    parameter int FS_W = kcg_pkg::KCG_FS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic            locked,
    input  logic [FS_W-1:0] wdata,
    output logic [FS_W-1:0] commit_q
);
    // Commit flop: all ones at reset, loads only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                 commit_q <= '1;
        else if (wr_hit && !locked) commit_q <= wdata;
    end
endmodule

// File: rtl/kcg_fsel_reg.sv
// Module: function-select register. Each bit has its own enable, gated by
// the matching commit bit. Assumes wr_hit is already qualified.
module kcg_fsel_reg #(
    parameter int FS_W = kcg_pkg::KCG_FS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [FS_W-1:0] commit,
    input  logic [FS_W-1:0] wdata,
    output logic [FS_W-1:0] fsel_q
);
    for (genvar i = 0; i < FS_W; i++) begin : g_bit
        // Per-bit flop: cleared at reset, written only where committed.
        always_ff @(posedge clk) begin
            if (!rst_n)                     fsel_q[i] <= 1'b0;
            else if (wr_hit && commit[i])   fsel_q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/keyed_commit_guard.sv
// Module: top of the keyed commit guard. It decodes the bus, qualifies the
// writes, holds the lock, commit and function-select state, and muxes reads.
// Assumes FS_W < DATA_W and a single synchronous clock domain.
module keyed_commit_guard #(
    parameter int ADDR_W = kcg_pkg::KCG_ADDR_W,
    parameter int DATA_W = kcg_pkg::KCG_DATA_W,
    parameter int FS_W   = kcg_pkg::KCG_FS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [FS_W-1:0]   func_sel
);
    import kcg_pkg::*;

    reg_sel_e        sel;
    logic            hit_lock, hit_commit, hit_fsel;
    logic            lock_q;
    logic [FS_W-1:0] commit_q;
    logic [FS_W-1:0] fsel_q;

    kcg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

    // Qualify each register write with the strobe.
    always_comb begin
        hit_lock   = wr_en && (sel == SEL_LOCK);
        hit_commit = wr_en && (sel == SEL_COMMIT);
        hit_fsel   = wr_en && (sel == SEL_FSEL);
    end

    kcg_lock_ctrl #(.DATA_W(DATA_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_lock),
        .wdata(wr_data), .locked(lock_q)
    );

    kcg_commit_reg #(.FS_W(FS_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_commit), .locked(lock_q),
        .wdata(wr_data[FS_W-1:0]), .commit_q(commit_q)
    );

    kcg_fsel_reg #(.FS_W(FS_W)) u_fsel (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_fsel), .commit(commit_q),
        .wdata(wr_data[FS_W-1:0]), .fsel_q(fsel_q)
    );

    // Read mux: zero-extended register values, zero for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_FSEL:   rd_data = DATA_W'(fsel_q);
            SEL_LOCK:   rd_data = DATA_W'(lock_q);
            SEL_COMMIT: rd_data = DATA_W'(commit_q);
            default:    rd_data = '0;
        endcase
    end

    // Drive the function-select value to the pin-mux logic.
    always_comb func_sel = fsel_q;
endmodule

// File: rtl/kcg_checker.sv
// Module: assertion checker for keyed_commit_guard, attached with bind.
// Assumes the same default offsets and key as the package.
module kcg_checker #(
    parameter int ADDR_W = kcg_pkg::KCG_ADDR_W,
    parameter int DATA_W = kcg_pkg::KCG_DATA_W,
    parameter int FS_W   = kcg_pkg::KCG_FS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              lock_q,
    input logic [FS_W-1:0]   commit_q,
    input logic [FS_W-1:0]   fsel_q
);
    import kcg_pkg::*;

    // R1: reset values are present when reset is released.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lock_q && commit_q == '1 && fsel_q == '0));

    // R2: the key opens the lock.
    a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_LOCK) && wr_data == DATA_W'(UNLOCK_KEY))
        |=> !lock_q);

    // R3: any other value closes it.
    a_r3_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_LOCK) && wr_data != DATA_W'(UNLOCK_KEY))
        |=> lock_q);

    // R4: the commit mask is frozen while locked.
    a_r4_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(commit_q));

    // R6: uncommitted function-select bits never move.
    a_r6_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((fsel_q ^ $past(fsel_q)) & ~$past(commit_q)) == '0));

    // R7: the lock moves only on lock-register writes.
    a_r7_lock_only_by_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(OFS_LOCK)) |=> $stable(lock_q));

    // R9: no state change without the strobe.
    a_r9_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(lock_q) && $stable(commit_q) && $stable(fsel_q)));
endmodule

bind keyed_commit_guard kcg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FS_W(FS_W)
) u_kcg_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .lock_q(lock_q), .commit_q(commit_q), .fsel_q(fsel_q)
);

// File: tb/keyed_commit_guard_bench.sv
// Bench: behavioural reference model, compared against the design every cycle.
module keyed_commit_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  func_sel;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    bit       m_locked = 1'b1;
    bit [7:0] m_commit = 8'hFF;
    bit [7:0] m_fsel   = 8'h00;

    keyed_commit_guard u_keyed_commit_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .func_sel(func_sel)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h000)      return {24'h0, m_fsel};
        else if (a == 12'h008) return {31'h0, m_locked};
        else if (a == 12'h00C) return {24'h0, m_commit};
        else                   return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check, take the edge, update the model.
    task automatic cyc(input string req, input bit we, input logic [11:0] a, input logic [31:0] d);
        wr_en = we; addr = a; wr_data = d;
        #1;
        check(req, rd_data, model_read(a));
        check({req, " func_sel"}, {24'h0, func_sel}, {24'h0, m_fsel});
        @(posedge clk);
        if (!rst_n) begin
            m_locked = 1'b1; m_commit = 8'hFF; m_fsel = 8'h00;
        end else if (we) begin
            if (a == 12'h008) m_locked = (d != 32'h0ACCE551);
            else if (a == 12'h00C) begin
                if (!m_locked) m_commit = d[7:0];
            end else if (a == 12'h000) begin
                for (int i = 0; i < 8; i++)
                    if (m_commit[i]) m_fsel[i] = d[i];
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        rst_n = 1'b0;
        // Hold reset for a few cycles. The model state already equals the reset values.
        repeat (3) begin
            wr_en = 1'b0; @(posedge clk); @(negedge clk);
        end
        rst_n = 1'b1;
        cyc("R1 lock reset",    1'b0, 12'h008, 32'h0);
        cyc("R1 commit reset",  1'b0, 12'h00C, 32'h0);
        cyc("R1 fsel reset",    1'b0, 12'h000, 32'h0);
        cyc("R6 full write",    1'b1, 12'h000, 32'hFFFF_FFA5);
        cyc("R8 fsel zero-ext", 1'b0, 12'h000, 32'h0);
        cyc("R4 locked commit", 1'b1, 12'h00C, 32'h0000_000F);
        cyc("R4 commit kept",   1'b0, 12'h00C, 32'h0);
        cyc("R3 near key",      1'b1, 12'h008, 32'h0ACC_E550);
        cyc("R3 still locked",  1'b0, 12'h008, 32'h0);
        cyc("R2 key",           1'b1, 12'h008, 32'h0ACC_E551);
        cyc("R2 unlocked",      1'b0, 12'h008, 32'h0);
        cyc("R5 commit write",  1'b1, 12'h00C, 32'h1234_5630);
        cyc("R5 low byte",      1'b0, 12'h00C, 32'h0);
        cyc("R7 lock kept",     1'b0, 12'h008, 32'h0);
        cyc("R5 commit 3C",     1'b1, 12'h00C, 32'hFFFF_FF3C);
        cyc("R7 lock open",     1'b0, 12'h008, 32'h0);
        cyc("R6 masked write",  1'b1, 12'h000, 32'h0000_005A);
        cyc("R6 read 99",       1'b0, 12'h000, 32'h0);
        check("R6 expected value", {24'h0, func_sel}, 32'h99);
        cyc("R9 no strobe",     1'b0, 12'h000, 32'h0000_00FF);
        cyc("R9 unchanged",     1'b0, 12'h000, 32'h0);
        cyc("R9 no strobe lock", 1'b0, 12'h008, 32'h0);
        cyc("R8 unmapped wr",   1'b1, 12'h004, 32'hFFFF_FFFF);
        cyc("R8 unmapped rd",   1'b0, 12'h004, 32'h0);
        cyc("R8 unmapped high", 1'b0, 12'hFFC, 32'h0);
        cyc("R10 fsel after",   1'b0, 12'h000, 32'h0);
        cyc("R3 relock zero",   1'b1, 12'h008, 32'h0);
        cyc("R4 commit ignored", 1'b1, 12'h00C, 32'h0000_00FF);
        cyc("R4 commit 3C kept", 1'b0, 12'h00C, 32'h0);
        cyc("R6 write zeros",   1'b1, 12'h000, 32'h0);
        cyc("R10 fsel 81",      1'b0, 12'h000, 32'h0);
        check("R6 expected 81", {24'h0, func_sel}, 32'h81);
        rst_n = 1'b0;
        cyc("R1 reset mid-run", 1'b0, 12'h000, 32'h0);
        rst_n = 1'b1;
        cyc("R1 fsel cleared",  1'b0, 12'h000, 32'h0);
        cyc("R1 relocked",      1'b0, 12'h008, 32'h0);
        cyc("R1 commit FF",     1'b0, 12'h00C, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule